// File: doc/BRIEF.md
# Fractional UART Baud-Rate Generator

This block turns the system clock into the 16x oversampling tick that a UART's transmitter and receiver step on. The clock-to-tick ratio is a divisor with a 16-bit whole part and a 6-bit fractional part. The divisor is the system clock divided by sixteen times the baud rate. The fractional field is the fractional part of that ratio times 64, rounded to the nearest integer. For example, a 20 MHz clock and 115200 baud give 10.8507, which is programmed as a whole part of 10 and a fractional field of 54.

Software loads the whole part and the fractional part into two holding registers. Neither value reaches the running divider until a line-control write copies both of them across at once. The run enable should be low while the divisor is changed, and software raises it as the last step of configuration.

Each tick period lasts the whole part in clocks. A 6-bit accumulator adds the fraction once per period. A period whose addition carries out of the accumulator lasts one extra clock. This spreads the remainder evenly, so that 64 periods take exactly 64 × whole + fraction clocks.

Top module: `fracBaudGen`

## Requirements
- R1: After reset the tick output is low, and both the held and the active divisor are zero. No tick appears until a non-zero whole part has been committed.
- R2: A whole-part write (wrInt high for one clock) stores wrData into a holding register only. The running tick stream does not change until a line-control strobe.
- R3: A fraction write (wrFrac high) keeps wrData[5:0] only. Bits 15 to 6 of wrData are ignored.
- R4: A line-control strobe (wrLineCtl high) copies both holding registers into the active divisor and restarts the period counter and the accumulator.
  - A holding write in the same clock as the strobe is not committed by that strobe.
  - After a strobe, the first tick follows after the new whole part in clocks.
- R5: While enable is low, the tick is low and the counter and accumulator are cleared. After enable rises, the first tick is high in the whole-part-th clock, counted from the first rising edge at which enable is sampled high.
- R6: An active whole part of zero produces no tick.
- R7: Each period lasts whole + c clocks. Here c is the carry out of the 6-bit sum accumulator + fraction. The accumulator takes that sum modulo 64 at each tick.
- R8: Over the first 64 periods after enabling, the total clock count is exactly 64 × whole + fraction.
- R9: The tick is a single-clock pulse whenever the whole part is 2 or more. With a whole part of 1 and a fraction of 0 it is high on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable for the divider |
| wrInt | input | 1 | Write strobe for the whole-part holding register |
| wrFrac | input | 1 | Write strobe for the fraction holding register |
| wrLineCtl | input | 1 | Line-control write strobe; commits the held divisor |
| wrData | input | 16 | Write data shared by both holding registers |
| tick | output | 1 | 16x oversampling tick |

## Verification
The bench targets the following mistakes:
- A divider that reads the holding registers directly would change speed on a bare whole-part write.
- A strobe that commits in the same clock as a write would pick up the new value.
- An accumulator that applies its carry one period late would lose one stretch in the first 64 periods, giving 693 instead of 694 clocks for 10 and 54.
- Ignoring the width of the fraction field would let the upper data bits corrupt the fraction.

The bench also covers a whole part of 1, where a tick must appear on every clock. It covers a whole part of 0, which must stay silent. It checks that the tick drops within one clock of the enable going low.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  typedef struct packed {
    logic loadInt;
    logic loadFrac;
    logic commit;
    logic run;
  } fbgStrobes_t;
endpackage

// File: rtl/fbgControl.sv
module fbgControl
  import fbg_pkg::*;
(
  input  logic        wrInt,
  input  logic        wrFrac,
  input  logic        wrLineCtl,
  input  logic        enable,
  input  logic        activeZero,
  output fbgStrobes_t strobes
);
  always_comb begin
    strobes.loadInt  = wrInt;
    strobes.loadFrac = wrFrac;
    strobes.commit   = wrLineCtl;
    // A commit restarts the divider, so counting pauses for that clock
    strobes.run      = enable && !activeZero && !wrLineCtl;
  end
endmodule

// File: rtl/fbgDatapath.sv
module fbgDatapath
  import fbg_pkg::*;
#(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [INT_W-1:0] wrData,
  input  fbgStrobes_t      strobes,
  output logic             activeZero,
  output logic             tick
);
  localparam int CNT_W = INT_W + 1;
  localparam int SUM_W = FRAC_W + 1;

  logic [INT_W-1:0]  intShadow, activeInt;
  logic [FRAC_W-1:0] fracShadow, activeFrac, accQ;
  logic [CNT_W-1:0]  cntQ, lastCount;
  logic [SUM_W-1:0]  fracSum;
  logic              stretch, periodEnd, tickQ;

  always_comb begin
    fracSum    = {1'b0, accQ} + {1'b0, activeFrac};
    stretch    = fracSum[FRAC_W];
    lastCount  = CNT_W'(activeInt) + CNT_W'(stretch) - CNT_W'(1);
    periodEnd  = (cntQ == lastCount);
    activeZero = (activeInt == '0);
  end

  // Holding and active divisor registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intShadow  <= '0;
      fracShadow <= '0;
      activeInt  <= '0;
      activeFrac <= '0;
    end else begin
      if (strobes.commit) begin
        activeInt  <= intShadow;
        activeFrac <= fracShadow;
      end
      if (strobes.loadInt)  intShadow  <= wrData;
      if (strobes.loadFrac) fracShadow <= wrData[FRAC_W-1:0];
    end
  end

  // Period counter, fractional accumulator, tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ  <= '0;
      accQ  <= '0;
      tickQ <= 1'b0;
    end else if (strobes.run) begin
      if (periodEnd) begin
        cntQ  <= '0;
        accQ  <= fracSum[FRAC_W-1:0];
        tickQ <= 1'b1;
      end else begin
        cntQ  <= cntQ + CNT_W'(1);
        tickQ <= 1'b0;
      end
    end else begin
      cntQ  <= '0;
      accQ  <= '0;
      tickQ <= 1'b0;
    end
  end

  assign tick = tickQ;

  p_commit_only_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commit |=> ($stable(activeInt) && $stable(activeFrac)));

  p_zero_silent_r6: assert property (@(posedge clk) disable iff (!rstN)
    activeZero |=> !tickQ);

  p_acc_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    tickQ |-> (accQ == FRAC_W'($past(accQ) + $past(activeFrac))));

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    (tickQ && activeInt > INT_W'(1)) |=> !tickQ);
endmodule

// File: rtl/fracBaudGen.sv
module fracBaudGen
  import fbg_pkg::*;
#(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             wrInt,
  input  logic             wrFrac,
  input  logic             wrLineCtl,
  input  logic [INT_W-1:0] wrData,
  output logic             tick
);
  fbgStrobes_t strobes;
  logic        activeZero;

  fbgControl u_control (
    .wrInt      (wrInt),
    .wrFrac     (wrFrac),
    .wrLineCtl  (wrLineCtl),
    .enable     (enable),
    .activeZero (activeZero),
    .strobes    (strobes)
  );

  fbgDatapath #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .wrData     (wrData),
    .strobes    (strobes),
    .activeZero (activeZero),
    .tick       (tick)
  );

  p_off_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !tick);

  p_commit_restart_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrLineCtl |=> !tick);
endmodule

// File: tb/fracBaudGen_bench.sv
module fracBaudGen_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        wrInt = 1'b0;
  logic        wrFrac = 1'b0;
  logic        wrLineCtl = 1'b0;
  logic [15:0] wrData = '0;
  logic        tick;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  fracBaudGen u_fracBaudGen (
    .clk(clk), .rstN(rstN), .enable(enable), .wrInt(wrInt), .wrFrac(wrFrac),
    .wrLineCtl(wrLineCtl), .wrData(wrData), .tick(tick)
  );

  // Behavioural reference model
  int  mShI = 0, mShF = 0, mI = 0, mF = 0, mCnt = 0, mAcc = 0;
  bit  mTick = 0;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mShI = 0; mShF = 0; mI = 0; mF = 0; mCnt = 0; mAcc = 0; mTick = 0;
    end else begin
      bit run;
      int len;
      run = enable && (mI != 0) && !wrLineCtl;
      if (run) begin
        len = mI + (((mAcc + mF) >= 64) ? 1 : 0);
        if (mCnt == len - 1) begin
          mCnt = 0; mAcc = (mAcc + mF) % 64; mTick = 1;
        end else begin
          mCnt = mCnt + 1; mTick = 0;
        end
      end else begin
        mCnt = 0; mAcc = 0; mTick = 0;
      end
      if (wrLineCtl) begin mI = mShI; mF = mShF; end
      if (wrInt)  mShI = int'(wrData);
      if (wrFrac) mShF = int'(wrData[5:0]);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rstN) check(tick === mTick, "R7", "cycle model tick", int'(tick), int'(mTick));
    if (cycles > 150000) begin
      check(1'b0, "R1", "watchdog expired", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic writeInt(input int v);
    @(negedge clk); wrInt = 1'b1; wrData = 16'(v);
    @(negedge clk); wrInt = 1'b0;
  endtask

  task automatic writeFrac(input int v);
    @(negedge clk); wrFrac = 1'b1; wrData = 16'(v);
    @(negedge clk); wrFrac = 1'b0;
  endtask

  task automatic commitLine();
    @(negedge clk); wrLineCtl = 1'b1;
    @(negedge clk); wrLineCtl = 1'b0;
  endtask

  task automatic countTicks(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tick) cnt++;
    end
  endtask

  task automatic measure(input int n, output int total, output int longCnt,
                         output int minG, output int maxG, output int firstG,
                         input int base);
    int gap = 0, k = 0, guard = 0;
    total = 0; longCnt = 0; minG = 1 << 30; maxG = 0; firstG = 0;
    while (k < n && guard < 40000) begin
      @(negedge clk);
      gap++; guard++;
      if (tick) begin
        if (k == 0) firstG = gap;
        total += gap;
        if (gap > base) longCnt++;
        if (gap < minG) minG = gap;
        if (gap > maxG) maxG = gap;
        gap = 0; k++;
      end
    end
  endtask

  initial begin
    int t, lc, mn, mx, fg, c;
    repeat (3) @(negedge clk);
    check(tick === 1'b0, "R1", "tick low in reset", int'(tick), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(tick === 1'b0, "R1", "tick low after reset", int'(tick), 0);
    enable = 1'b1;
    countTicks(40, c);
    check(c == 0, "R1", "no tick before any commit", c, 0);
    @(negedge clk); enable = 1'b0;

    writeInt(10); writeFrac(54);
    @(negedge clk); enable = 1'b1;
    countTicks(100, c);
    check(c == 0, "R2", "uncommitted divisor silent", c, 0);
    @(negedge clk); enable = 1'b0;

    commitLine();
    enable = 1'b1;
    measure(64, t, lc, mn, mx, fg, 10);
    check(fg == 10, "R5", "first tick after whole part", fg, 10);
    check(t == 694, "R8", "64 periods for 10 and 54", t, 694);
    check(lc == 54, "R7", "stretched periods for 54", lc, 54);
    check(mn == 10 && mx == 11, "R7", "period bounds 10..11", mx, 11);
    @(negedge clk); enable = 1'b0;
    @(negedge clk);
    check(tick === 1'b0, "R5", "tick low after disable", int'(tick), 0);

    writeFrac(16'hFFC5); commitLine();
    enable = 1'b1;
    measure(64, t, lc, mn, mx, fg, 10);
    check(t == 645, "R3", "upper fraction bits ignored", t, 645);
    check(lc == 5, "R3", "stretched periods for 5", lc, 5);
    @(negedge clk); enable = 1'b0;

    writeInt(1); writeFrac(0); commitLine();
    enable = 1'b1;
    countTicks(20, c);
    check(c == 19 || c == 20, "R9", "tick every clock at 1", c, 20);
    measure(20, t, lc, mn, mx, fg, 1);
    check(t == 20 && mx == 1, "R7", "whole part 1 period", t, 20);
    @(negedge clk); enable = 1'b0;

    writeInt(3); writeFrac(32); commitLine();
    enable = 1'b1;
    measure(64, t, lc, mn, mx, fg, 3);
    check(t == 224, "R8", "64 periods for 3 and 32", t, 224);
    check(lc == 32, "R7", "alternating stretch", lc, 32);
    check(mn >= 2, "R9", "single-clock pulse", mn, 3);
    @(negedge clk); enable = 1'b0;

    writeFrac(0); writeInt(7); commitLine();
    enable = 1'b1;
    repeat (20) @(negedge clk);
    @(negedge clk); wrInt = 1'b1; wrLineCtl = 1'b1; wrData = 16'd5;
    @(negedge clk); wrInt = 1'b0; wrLineCtl = 1'b0;
    measure(8, t, lc, mn, mx, fg, 7);
    check(fg == 7 && mx == 7, "R4", "same-clock write not committed", mx, 7);
    commitLine();
    measure(8, t, lc, mn, mx, fg, 5);
    check(fg == 5 && mx == 5, "R4", "later commit takes held value", mx, 5);

    @(negedge clk); enable = 1'b0;
    countTicks(30, c);
    check(c == 0, "R5", "silent while disabled", c, 0);

    writeInt(0); commitLine();
    enable = 1'b1;
    countTicks(50, c);
    check(c == 0, "R6", "zero whole part silent", c, 0);
    @(negedge clk); enable = 1'b0;

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule